// File: doc/BRIEF.md
# Frame-Based Credit Bandwidth Regulator

This block meters how many memory operations each of several cores may start. Time is cut into frames that every core shares. A single frame timer marks each boundary. At that boundary every core's credit counter is refilled from its programmed allocation. One credit lets a core start one memory operation, and that one credit covers the operation's worst-case traffic on every network it may touch. While a core has credit and asserts its request, it is granted one operation per cycle.

A core that holds credit but does not request in a cycle gives up one credit to a shared pool. Only cores flagged secure may draw from that pool, and only once their own credits are used up. When several secure cores want a pool credit in the same cycle, a rotating pointer picks one. The pool is emptied at every frame boundary, so a spare credit never lasts past its frame. Insecure cores are therefore held to their own allocation, and their timing cannot be shaped by what secure cores do. A request that finds no credit is not lost: the requester keeps it asserted and is granted once credit returns.

The frame length and the allocations are sampled only at a boundary, so changing them in the middle of a frame affects only the next frame.

Top module: `frame_credit_regulator`

## Requirements
- R1: While `rst` is high, `grant` and `frame_last` are all zero.
- R2: `frame_last` pulses once per frame. Consecutive pulses are L cycles apart, where L is `frame_len_cfg` sampled at the boundary that opened the frame; a value of 0 is treated as 1. The first frame after reset is one cycle long.
- R3: At every boundary, core i's own credit is set to `alloc_cfg[i*CRED_W +: CRED_W]`. When core i requests in every cycle and draws nothing from the pool, it receives min(alloc, L) grants in that frame.
- R4: `grant[i]` is high exactly one cycle after a cycle in which core i requested and was served. A core that does not request is never granted.
- R5: A core whose `secure` bit is 0 receives no more grants per frame than its allocation, whatever the other cores do.
- R6: A request made when the core has no credit is held pending and is served in the first cycle of the next frame. With allocation A and a constant request, the grants fall on the first A cycles of every frame.
- R7: In each cycle in which a core holds credit but does not request, one of its credits moves into the shared pool. The pool can serve that credit from the next cycle on.
- R8: A core with `secure` = 1, a request and no own credit takes one credit from the pool when the pool is nonempty. A core with `secure` = 0 never takes a pool credit.
- R9: The pool is emptied at every frame boundary, so a pool credit can never be used in the first cycle of a frame.
- R10: At most one pool credit is granted per cycle. Contending secure cores are served in rotating order, starting after the last core that won.
- R11: A change to `alloc_cfg` or `frame_len_cfg` made after a boundary has no effect on the frame already running and takes effect from the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | N_CORES | Per-core request to start one memory operation |
| secure | input | N_CORES | Per-core flag allowing use of pooled credits |
| alloc_cfg | input | N_CORES*CRED_W | Per-core credit allocation, core i at bits [i*CRED_W +: CRED_W] |
| frame_len_cfg | input | FRAME_W | Frame length in cycles, 0 treated as 1 |
| grant | output | N_CORES | Registered per-core grant, one operation per high cycle |
| frame_last | output | 1 | Registered marker on the cycle carrying the last grant of a frame |

## Verification
The assertions rely on reset being high from the very first clock edge and on every input holding a known value at each rising edge. The pool width is taken to be large enough, which holds because it is sized from the core count and the credit width. The bench changes inputs only on falling edges. It changes configuration either under reset or right after a frame marker, never in the middle of a frame it is measuring. The allocations and frame lengths it uses keep each frame's total spare credit far below the pool's range.

// File: rtl/frc_pkg.sv
package frc_pkg;
  localparam int unsigned FRC_CORES_DEF = 4;
  localparam int unsigned FRC_CRED_W_DEF = 4;
  localparam int unsigned FRC_FRAME_W_DEF = 8;

  // Width of the shared pool: large enough for every core's full allocation.
  function automatic int unsigned pool_width(input int unsigned cores, input int unsigned cred_w);
    return cred_w + $clog2(cores) + 1;
  endfunction
endpackage

// File: rtl/frc_frame_timer.sv
module frc_frame_timer #(
  parameter int unsigned FRAME_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [FRAME_W-1:0] len_cfg,
  output logic               load
);
  logic [FRAME_W-1:0] cnt_q;
  logic [FRAME_W-1:0] len_q;

  assign load = (cnt_q == len_q - FRAME_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      len_q <= FRAME_W'(1);
    end else if (load) begin
      cnt_q <= '0;
      len_q <= (len_cfg == '0) ? FRAME_W'(1) : len_cfg;
    end else begin
      cnt_q <= cnt_q + FRAME_W'(1);
    end
  end
endmodule

// File: rtl/frc_credit_slot.sv
module frc_credit_slot #(
  parameter int unsigned CRED_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [CRED_W-1:0] alloc,
  input  logic              req,
  output logic              has_cred,
  output logic              own_use,
  output logic              donate
);
  logic [CRED_W-1:0] cred_q;

  assign has_cred = (cred_q != '0);
  assign own_use  = req & has_cred;
  assign donate   = ~req & has_cred;

  // Every cycle with credit spends one: either used or handed to the pool.
  always_ff @(posedge clk) begin
    if (rst) begin
      cred_q <= '0;
    end else if (load) begin
      cred_q <= alloc;
    end else if (has_cred) begin
      cred_q <= cred_q - CRED_W'(1);
    end
  end
endmodule

// File: rtl/frc_pool_arbiter.sv
module frc_pool_arbiter #(
  parameter int unsigned N_CORES = 4,
  parameter int unsigned POOL_W  = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [N_CORES-1:0] want,
  input  logic [N_CORES-1:0] donate,
  output logic [N_CORES-1:0] pool_win,
  output logic [POOL_W-1:0]  pool_cnt
);
  localparam int unsigned IDX_W = (N_CORES > 1) ? $clog2(N_CORES) : 1;

  logic [POOL_W-1:0] pool_q;
  logic [POOL_W-1:0] don_sum;
  logic [IDX_W-1:0]  ptr_q;
  logic [IDX_W-1:0]  win_idx;
  logic              found;

  assign pool_cnt = pool_q;

  always_comb begin
    don_sum = '0;
    for (int i = 0; i < int'(N_CORES); i++) begin
      don_sum = don_sum + POOL_W'(donate[i]);
    end
  end

  always_comb begin
    pool_win = '0;
    found    = 1'b0;
    win_idx  = ptr_q;
    for (int k = 0; k < int'(N_CORES); k++) begin
      int idx;
      idx = int'(ptr_q) + k;
      if (idx >= int'(N_CORES)) idx = idx - int'(N_CORES);
      if (!found && want[idx] && (pool_q != '0)) begin
        found   = 1'b1;
        win_idx = IDX_W'(idx);
      end
    end
    if (found) pool_win[win_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pool_q <= '0;
      ptr_q  <= '0;
    end else begin
      if (load) begin
        pool_q <= '0;
      end else begin
        pool_q <= pool_q - POOL_W'(found) + don_sum;
      end
      if (found) begin
        ptr_q <= (win_idx == IDX_W'(N_CORES - 1)) ? '0 : win_idx + IDX_W'(1);
      end
    end
  end
endmodule

// File: rtl/frame_credit_regulator.sv
module frame_credit_regulator
  import frc_pkg::*;
#(
  parameter int unsigned N_CORES = FRC_CORES_DEF,
  parameter int unsigned CRED_W  = FRC_CRED_W_DEF,
  parameter int unsigned FRAME_W = FRC_FRAME_W_DEF
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [N_CORES-1:0]        req_valid,
  input  logic [N_CORES-1:0]        secure,
  input  logic [N_CORES*CRED_W-1:0] alloc_cfg,
  input  logic [FRAME_W-1:0]        frame_len_cfg,
  output logic [N_CORES-1:0]        grant,
  output logic                      frame_last
);
  localparam int unsigned POOL_W = pool_width(N_CORES, CRED_W);

  logic               frame_load;
  logic [N_CORES-1:0] has_cred;
  logic [N_CORES-1:0] own_use;
  logic [N_CORES-1:0] donate;
  logic [N_CORES-1:0] want;
  logic [N_CORES-1:0] pool_win;
  logic [POOL_W-1:0]  pool_cnt;

  frc_frame_timer #(.FRAME_W(FRAME_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .len_cfg (frame_len_cfg),
    .load    (frame_load)
  );

  for (genvar g = 0; g < int'(N_CORES); g++) begin : g_slot
    frc_credit_slot #(.CRED_W(CRED_W)) u_slot (
      .clk      (clk),
      .rst      (rst),
      .load     (frame_load),
      .alloc    (alloc_cfg[g*CRED_W +: CRED_W]),
      .req      (req_valid[g]),
      .has_cred (has_cred[g]),
      .own_use  (own_use[g]),
      .donate   (donate[g])
    );
  end

  assign want = req_valid & secure & ~has_cred;

  frc_pool_arbiter #(.N_CORES(N_CORES), .POOL_W(POOL_W)) u_pool (
    .clk      (clk),
    .rst      (rst),
    .load     (frame_load),
    .want     (want),
    .donate   (donate),
    .pool_win (pool_win),
    .pool_cnt (pool_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      grant      <= '0;
      frame_last <= 1'b0;
    end else begin
      grant      <= own_use | pool_win;
      frame_last <= frame_load;
    end
  end
endmodule

// File: rtl/frc_checker.sv
module frc_checker #(
  parameter int unsigned N_CORES = 4,
  parameter int unsigned POOL_W  = 7
) (
  input logic               clk,
  input logic               rst,
  input logic [N_CORES-1:0] req_valid,
  input logic [N_CORES-1:0] secure,
  input logic [N_CORES-1:0] grant,
  input logic [N_CORES-1:0] has_cred,
  input logic [N_CORES-1:0] pool_win,
  input logic [POOL_W-1:0]  pool_cnt,
  input logic               frame_load
);
  // R4
  no_grant_without_req_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((grant & ~$past(req_valid)) == '0));

  // R5
  insecure_needs_credit_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((grant & ~$past(secure) & ~$past(has_cred)) == '0));

  // R10
  single_pool_win_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pool_win));

  // R8
  pool_win_needs_pool_chk: assert property (@(posedge clk) disable iff (rst)
    (pool_win != '0) |-> (pool_cnt != '0));

  // R9
  pool_clear_chk: assert property (@(posedge clk) disable iff (rst)
    frame_load |=> (pool_cnt == '0));
endmodule

bind frame_credit_regulator frc_checker #(.N_CORES(N_CORES), .POOL_W(POOL_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .secure     (secure),
  .grant      (grant),
  .has_cred   (has_cred),
  .pool_win   (pool_win),
  .pool_cnt   (pool_cnt),
  .frame_load (frame_load)
);

// File: tb/frame_credit_regulator_tb.sv
module frame_credit_regulator_tb;
  localparam int NC = 4;
  localparam int CW = 4;
  localparam int FW = 8;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NC-1:0]   req_valid = '0;
  logic [NC-1:0]   secure = '0;
  logic [NC*CW-1:0] alloc_cfg = '0;
  logic [FW-1:0]   frame_len_cfg = FW'(1);
  logic [NC-1:0]   grant;
  logic            frame_last;

  int tests = 0;
  int fails = 0;
  int cyc_total = 0;
  int flen;
  int cnt [NC];
  int pm  [NC];
  int repeats;
  int multi;

  frame_credit_regulator #(.N_CORES(NC), .CRED_W(CW), .FRAME_W(FW)) u_dut (
    .clk (clk), .rst (rst), .req_valid (req_valid), .secure (secure),
    .alloc_cfg (alloc_cfg), .frame_len_cfg (frame_len_cfg),
    .grant (grant), .frame_last (frame_last)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc_total <= cyc_total + 1;

  initial begin
    wait (cyc_total > 150000);
    fails++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc_total);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_alloc(input int a0, input int a1, input int a2, input int a3);
    alloc_cfg = {CW'(a3), CW'(a2), CW'(a1), CW'(a0)};
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) begin
      @(negedge clk);
      check(grant == '0 && frame_last == 1'b0, "R1", int'({grant, frame_last}), 0);
    end
    rst = 1'b0;
  endtask

  // Collect one frame window ending with the frame_last cycle.
  task automatic run_frame();
    int prev;
    bit done;
    flen = 0; repeats = 0; multi = 0; prev = -1; done = 1'b0;
    for (int i = 0; i < NC; i++) begin cnt[i] = 0; pm[i] = 0; end
    for (int c = 0; c < 64 && !done; c++) begin
      @(negedge clk);
      flen++;
      for (int i = 0; i < NC; i++) begin
        if (grant[i]) begin
          cnt[i]++;
          if (flen <= 30) pm[i] = pm[i] | (1 << (flen - 1));
        end
      end
      if ($countones(grant[NC-1:1]) > 1) multi++;
      for (int k = 1; k < NC; k++) begin
        if (grant[k]) begin
          if (k == prev) repeats++;
          prev = k;
        end
      end
      if (frame_last) done = 1'b1;
    end
  endtask

  function automatic int imin(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  initial begin
    int al [NC];
    int el;

    // Sweep: all insecure, constant requests, varied lengths and allocations.
    for (int L = 0; L <= 6; L++) begin
      for (int b = 0; b < 4; b++) begin
        el = (L == 0) ? 1 : L;
        for (int i = 0; i < NC; i++) al[i] = (b + 2 * i) % 9;
        set_alloc(al[0], al[1], al[2], al[3]);
        frame_len_cfg = FW'(L);
        secure = '0;
        req_valid = '1;
        do_reset();
        run_frame();
        // R2: first frame after reset is one cycle with nothing granted
        check(flen == 1, "R2", flen, 1);
        check(cnt[0] + cnt[1] + cnt[2] + cnt[3] == 0, "R3", cnt[0] + cnt[1] + cnt[2] + cnt[3], 0);
        for (int f = 0; f < 2; f++) begin
          run_frame();
          check(flen == el, "R2", flen, el);
          for (int i = 0; i < NC; i++) begin
            check(cnt[i] == imin(al[i], el), "R3", cnt[i], imin(al[i], el));
            check(cnt[i] <= al[i], "R5", cnt[i], al[i]);
          end
        end
      end
    end

    // R6: held requests resume at frame start; R4: idle cores get nothing.
    set_alloc(2, 3, 0, 0);
    frame_len_cfg = FW'(5);
    secure = '0;
    req_valid = 4'b0001;
    do_reset();
    run_frame();
    for (int f = 0; f < 3; f++) begin
      run_frame();
      check(pm[0] == 3, "R6", pm[0], 3);
      check(cnt[1] + cnt[2] + cnt[3] == 0, "R4", cnt[1] + cnt[2] + cnt[3], 0);
    end

    // R7, R8: idle core donates, secure core consumes pool one cycle later.
    set_alloc(4, 0, 0, 0);
    frame_len_cfg = FW'(10);
    secure = 4'b0010;
    req_valid = 4'b0010;
    do_reset();
    run_frame();
    for (int f = 0; f < 2; f++) begin
      run_frame();
      check(cnt[1] == 4, "R8", cnt[1], 4);
      check(pm[1] == 30, "R7", pm[1], 30);
      check(cnt[0] == 0, "R4", cnt[0], 0);
    end
    secure = 4'b0000;
    run_frame();
    for (int f = 0; f < 2; f++) begin
      run_frame();
      check(cnt[1] == 0, "R5", cnt[1], 0);
    end

    // R9: leftover pool never used in first cycle of next frame.
    set_alloc(6, 0, 0, 0);
    frame_len_cfg = FW'(4);
    secure = 4'b0010;
    req_valid = 4'b0010;
    do_reset();
    run_frame();
    for (int f = 0; f < 3; f++) begin
      run_frame();
      check(cnt[1] == 3, "R9", cnt[1], 3);
      check(pm[1] == 14, "R9", pm[1], 14);
    end

    // R10: three secure contenders share the pool in rotation.
    set_alloc(15, 0, 0, 0);
    frame_len_cfg = FW'(13);
    secure = 4'b1110;
    req_valid = 4'b1110;
    do_reset();
    run_frame();
    for (int f = 0; f < 2; f++) begin
      run_frame();
      for (int k = 1; k < NC; k++) check(cnt[k] == 4, "R10", cnt[k], 4);
      check(multi == 0, "R10", multi, 0);
      check(repeats == 0, "R10", repeats, 0);
    end

    // R11: mid-run configuration change waits for the next boundary.
    set_alloc(2, 2, 0, 0);
    frame_len_cfg = FW'(6);
    secure = '0;
    req_valid = 4'b0011;
    do_reset();
    run_frame();
    run_frame();
    check(cnt[0] == 2 && cnt[1] == 2, "R3", cnt[0] * 10 + cnt[1], 22);
    set_alloc(5, 1, 0, 0);
    frame_len_cfg = FW'(8);
    run_frame();
    check(flen == 6, "R11", flen, 6);
    check(cnt[0] == 2 && cnt[1] == 2, "R11", cnt[0] * 10 + cnt[1], 22);
    run_frame();
    check(flen == 8, "R11", flen, 8);
    check(cnt[0] == 5 && cnt[1] == 1, "R11", cnt[0] * 10 + cnt[1], 51);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule